// File: doc/BRIEF.md
# K-Modulus Loop Filter

This block is the loop filter of an all-digital phase-locked loop. It is a reversible counter clocked at K times the loop centre frequency. A one-bit phase-error level sets its direction: high counts down and low counts up. When the count runs off the top of its range the block emits a one-cycle carry pulse. When it runs off the bottom it emits a one-cycle borrow pulse. A pulse add/delete oscillator downstream uses these pulses to advance or retard its output phase.

The range is a power of two chosen at run time by a 4-bit code, from 2^3 up to 2^17. After every carry or borrow the count returns to the middle of the range, so only a sustained bias in the phase error produces the next pulse. When the loop is in lock, the phase error is a balanced square wave and the count only wanders around the midpoint. All inputs are plain levels sampled on the clock. The outputs are registered.

Top module: `kmod_loop_filter`

## Requirements
- R1: The exponent is E = mod_code + 3, and codes 14 and 15 both give E = 17. The modulus is M = 2^E, the count range is 0 to M-1 and the midpoint is M/2. Examples: code 0 gives midpoint 4, code 5 gives midpoint 128, and code 15 gives midpoint 65536.
- R2: Outside reset, pulse and code-change cycles, each clock adds 1 to count when phase_err is 0 and subtracts 1 when phase_err is 1.
- R3: A clock with phase_err 0 while count equals M-1 sets up_pulse for exactly the next cycle and loads count with M/2. Starting from the midpoint, the 4th consecutive up step carries when M is 8.
- R4: A clock with phase_err 1 while count equals 0 sets dn_pulse for exactly the next cycle and loads count with M/2. Starting from the midpoint, the 5th consecutive down step borrows when M is 8.
- R5: up_pulse and dn_pulse are never high together, and neither stays high for two cycles in a row.
- R6: A phase_err that toggles every clock (a locked, 50% square wave) never produces a pulse.
- R7: A clock with rst high loads count with the midpoint for the current mod_code and clears both pulses.
- R8: When mod_code differs from its value at the previous clock, the next clock loads count with the new midpoint and emits no pulse.
- R9: count never exceeds M-1 for the code in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock, K times the centre frequency |
| rst | input | 1 | Synchronous reset, active high |
| phase_err | input | 1 | Phase-detector level: 1 counts down, 0 counts up |
| mod_code | input | 4 | Modulus select code |
| up_pulse | output | 1 | One-cycle carry pulse |
| dn_pulse | output | 1 | One-cycle borrow pulse |
| count | output | 17 | Current counter value |

## Verification
The assertions assume that phase_err, mod_code and rst are always known values that change only between clock edges. Within that, phase_err and mod_code may change on any cycle. The stimulus drives every input on the falling edge. It changes mod_code rarely and mostly among small codes, so that carries and borrows happen often. It also biases phase_err by a random amount per segment, so that both ends of the range are reached as well as the balanced case.

// File: rtl/kfilt_pkg.sv
package kfilt_pkg;
  typedef enum logic [2:0] {
    ACT_RELOAD = 3'd0,
    ACT_INC    = 3'd1,
    ACT_DEC    = 3'd2,
    ACT_CARRY  = 3'd3,
    ACT_BORROW = 3'd4
  } kfilt_act_e;
endpackage

// File: rtl/kfilt_range.sv
module kfilt_range #(
  parameter int CNT_W   = 17,
  parameter int CODE_W  = 4,
  parameter int MIN_EXP = 3
) (
  input  logic [CODE_W-1:0] mod_code,
  output logic [CNT_W-1:0]  top,
  output logic [CNT_W-1:0]  mid
);
  localparam int SUM_MAX = (1 << CODE_W) - 1 + MIN_EXP;
  localparam int EXP_W   = $clog2(SUM_MAX + 1) + 1;

  logic [EXP_W-1:0] raw_exp;
  logic [EXP_W-1:0] exp_q;

  always_comb begin
    raw_exp = EXP_W'(mod_code) + EXP_W'(MIN_EXP);
    exp_q   = (raw_exp > EXP_W'(CNT_W)) ? EXP_W'(CNT_W) : raw_exp;
  end

  // One candidate per legal exponent; the matching one drives the outputs.
  logic [CNT_W-1:0] top_opt [MIN_EXP:CNT_W];
  logic [CNT_W-1:0] mid_opt [MIN_EXP:CNT_W];
  logic [CNT_W:MIN_EXP] hit;

  for (genvar k = MIN_EXP; k <= CNT_W; k++) begin : g_exp
    assign top_opt[k] = CNT_W'((64'd1 << k) - 64'd1);
    assign mid_opt[k] = CNT_W'(64'd1 << (k - 1));
    assign hit[k]     = (exp_q == EXP_W'(k));
  end

  always_comb begin
    top = '0;
    mid = '0;
    for (int k = MIN_EXP; k <= CNT_W; k++) begin
      if (hit[k]) begin
        top = top | top_opt[k];
        mid = mid | mid_opt[k];
      end
    end
  end
endmodule

// File: rtl/kfilt_step.sv
module kfilt_step
  import kfilt_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic             rst,
  input  logic             code_chg,
  input  logic             phase_err,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] top,
  input  logic [CNT_W-1:0] mid,
  output kfilt_act_e       act,
  output logic [CNT_W-1:0] count_nx,
  output logic             up_nx,
  output logic             dn_nx
);
  always_comb begin
    if (rst || code_chg)          act = ACT_RELOAD;
    else if (!phase_err)          act = (count == top) ? ACT_CARRY : ACT_INC;
    else                          act = (count == '0) ? ACT_BORROW : ACT_DEC;
  end

  always_comb begin
    count_nx = mid;
    up_nx    = 1'b0;
    dn_nx    = 1'b0;
    unique case (act)
      ACT_INC:    count_nx = count + CNT_W'(1);
      ACT_DEC:    count_nx = count - CNT_W'(1);
      ACT_CARRY:  up_nx    = 1'b1;
      ACT_BORROW: dn_nx    = 1'b1;
      default:    count_nx = mid;
    endcase
  end
endmodule

// File: rtl/kfilt_core.sv
module kfilt_core
  import kfilt_pkg::*;
#(
  parameter int CNT_W  = 17,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phase_err,
  input  logic [CODE_W-1:0] mod_code,
  input  logic [CNT_W-1:0]  top,
  input  logic [CNT_W-1:0]  mid,
  output logic [CNT_W-1:0]  count,
  output logic              up_pulse,
  output logic              dn_pulse
);
  logic [CODE_W-1:0] code_q;
  logic              code_chg;
  kfilt_act_e        act;
  logic [CNT_W-1:0]  count_nx;
  logic              up_nx;
  logic              dn_nx;

  assign code_chg = (mod_code != code_q);

  kfilt_step #(.CNT_W(CNT_W)) u_step (
    .rst       (rst),
    .code_chg  (code_chg),
    .phase_err (phase_err),
    .count     (count),
    .top       (top),
    .mid       (mid),
    .act       (act),
    .count_nx  (count_nx),
    .up_nx     (up_nx),
    .dn_nx     (dn_nx)
  );

  always_ff @(posedge clk) begin
    code_q   <= mod_code;
    count    <= count_nx;
    up_pulse <= up_nx;
    dn_pulse <= dn_nx;
  end

  logic unused_act;
  assign unused_act = ^act;
endmodule

// File: rtl/kmod_loop_filter.sv
module kmod_loop_filter #(
  parameter int CNT_W   = 17,
  parameter int CODE_W  = 4,
  parameter int MIN_EXP = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phase_err,
  input  logic [CODE_W-1:0] mod_code,
  output logic              up_pulse,
  output logic              dn_pulse,
  output logic [CNT_W-1:0]  count
);
  logic [CNT_W-1:0] top;
  logic [CNT_W-1:0] mid;

  kfilt_range #(.CNT_W(CNT_W), .CODE_W(CODE_W), .MIN_EXP(MIN_EXP)) u_range (
    .mod_code (mod_code),
    .top      (top),
    .mid      (mid)
  );

  kfilt_core #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .phase_err (phase_err),
    .mod_code  (mod_code),
    .top       (top),
    .mid       (mid),
    .count     (count),
    .up_pulse  (up_pulse),
    .dn_pulse  (dn_pulse)
  );
endmodule

// File: rtl/kfilt_checker.sv
module kfilt_checker #(
  parameter int CNT_W   = 17,
  parameter int CODE_W  = 4,
  parameter int MIN_EXP = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              phase_err,
  input logic [CODE_W-1:0] mod_code,
  input logic              up_pulse,
  input logic              dn_pulse,
  input logic [CNT_W-1:0]  count
);
  function automatic logic [CNT_W-1:0] c_mid(input logic [CODE_W-1:0] c);
    int e;
    e = int'(c) + MIN_EXP;
    if (e > CNT_W) e = CNT_W;
    return CNT_W'(64'd1 << (e - 1));
  endfunction

  function automatic logic [CNT_W-1:0] c_top(input logic [CODE_W-1:0] c);
    return CNT_W'({1'b0, c_mid(c)} * 2 - 1);
  endfunction

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({up_pulse, dn_pulse}));

  assert_up_single_R5: assert property (@(posedge clk) disable iff (rst)
    up_pulse |=> !up_pulse);

  assert_dn_single_R5: assert property (@(posedge clk) disable iff (rst)
    dn_pulse |=> !dn_pulse);

  assert_carry_R3: assert property (@(posedge clk) disable iff (rst)
    up_pulse |-> (!$past(phase_err) && count == c_mid($past(mod_code))
                  && $past(count) == c_top($past(mod_code))));

  assert_borrow_R4: assert property (@(posedge clk) disable iff (rst)
    dn_pulse |-> ($past(phase_err) && count == c_mid($past(mod_code))
                  && $past(count) == '0));

  assert_reset_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count == c_mid($past(mod_code)) && !up_pulse && !dn_pulse));

  assert_code_change_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mod_code) != $past(mod_code, 2))
      |-> (count == c_mid($past(mod_code)) && !up_pulse && !dn_pulse));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mod_code) == $past(mod_code, 2) && !up_pulse && !dn_pulse)
      |-> (count == ($past(phase_err) ? $past(count) - CNT_W'(1)
                                      : $past(count) + CNT_W'(1))));

  assert_range_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(mod_code)) |-> (count <= c_top(mod_code)));
endmodule

bind kmod_loop_filter kfilt_checker #(
  .CNT_W(CNT_W), .CODE_W(CODE_W), .MIN_EXP(MIN_EXP)
) u_kfilt_checker (
  .clk       (clk),
  .rst       (rst),
  .phase_err (phase_err),
  .mod_code  (mod_code),
  .up_pulse  (up_pulse),
  .dn_pulse  (dn_pulse),
  .count     (count)
);

// File: tb/tb_kmod_loop_filter.sv
module tb_kmod_loop_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phase_err = 1'b0;
  logic [3:0]  mod_code = 4'd0;
  logic        up_pulse;
  logic        dn_pulse;
  logic [16:0] count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int unsigned m_count;
  bit          m_up, m_dn;
  logic [3:0]  m_codeq;
  int          n_up, n_dn;

  always #5 clk = ~clk;

  kmod_loop_filter dut (
    .clk(clk), .rst(rst), .phase_err(phase_err), .mod_code(mod_code),
    .up_pulse(up_pulse), .dn_pulse(dn_pulse), .count(count)
  );

  function automatic int unsigned exp_mid(input logic [3:0] c);
    int e;
    e = int'(c) + 3;
    if (e > 17) e = 17;
    return 32'd1 << (e - 1);
  endfunction

  function automatic int unsigned exp_top(input logic [3:0] c);
    return 2 * exp_mid(c) - 1;
  endfunction

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model(input bit r, input bit p, input logic [3:0] c);
    string tag;
    m_up = 0; m_dn = 0;
    if (r) begin
      m_count = exp_mid(c); tag = "R7";
    end else if (c != m_codeq) begin
      m_count = exp_mid(c); tag = "R8";
    end else if (!p) begin
      if (m_count == exp_top(c)) begin m_up = 1; m_count = exp_mid(c); tag = "R3"; end
      else begin m_count++; tag = "R2"; end
    end else begin
      if (m_count == 0) begin m_dn = 1; m_count = exp_mid(c); tag = "R4"; end
      else begin m_count--; tag = "R2"; end
    end
    m_codeq = c;
    @(negedge clk);
    chk({tag, " count"}, count, m_count);
    chk("R3 up_pulse", up_pulse, m_up);
    chk("R4 dn_pulse", dn_pulse, m_dn);
    chk("R5 exclusive", up_pulse & dn_pulse, 0);
    chk("R9 range", count <= exp_top(c), 1);
    if (up_pulse) n_up++;
    if (dn_pulse) n_dn++;
  endtask

  task automatic cyc(input bit r, input bit p, input logic [3:0] c);
    rst = r; phase_err = p; mod_code = c;
    @(posedge clk);
    model(r, p, c);
  endtask

  initial begin
    int bias;
    logic [3:0] code;
    void'($urandom(32'd4242));
    @(negedge clk);
    for (int i = 0; i < 3; i++) cyc(1, 0, 4'd0);
    chk("R7 reset count", count, 4);
    chk("R7 reset pulses", up_pulse | dn_pulse, 0);

    // R3: M=8 from midpoint, 4th up step carries
    n_up = 0;
    for (int i = 0; i < 3; i++) cyc(0, 0, 4'd0);
    chk("R3 no early carry", n_up, 0);
    cyc(0, 0, 4'd0);
    chk("R3 carry on 4th step", up_pulse, 1);
    chk("R3 reload mid", count, 4);

    // R4: 5th down step borrows
    n_dn = 0;
    for (int i = 0; i < 4; i++) cyc(0, 1, 4'd0);
    chk("R4 no early borrow", n_dn, 0);
    cyc(0, 1, 4'd0);
    chk("R4 borrow on 5th step", dn_pulse, 1);
    chk("R4 reload mid", count, 4);

    // R1 / R8: code mapping and reload on change
    cyc(0, 0, 4'd15);
    chk("R1 code 15 mid", count, 65536);
    cyc(0, 0, 4'd15);
    chk("R1 code 15 step", count, 65537);
    cyc(0, 1, 4'd14);
    chk("R8 code change reload", count, 65536);
    chk("R8 no pulse", up_pulse | dn_pulse, 0);
    cyc(0, 0, 4'd5);
    chk("R1 code 5 mid", count, 128);

    // R6: locked square wave
    n_up = 0; n_dn = 0;
    cyc(0, 0, 4'd0);
    for (int i = 0; i < 400; i++) cyc(0, i[0], 4'd0);
    chk("R6 no pulses in lock", n_up + n_dn, 0);

    // R7: reset mid-run
    cyc(0, 0, 4'd2);
    cyc(0, 0, 4'd2);
    cyc(1, 0, 4'd2);
    chk("R7 reset mid-run", count, 16);

    // random segments
    code = 4'd0;
    for (int s = 0; s < 120; s++) begin
      if ($urandom_range(0, 3) == 0) code = 4'($urandom_range(0, 4));
      if ($urandom_range(0, 30) == 0) code = 4'($urandom_range(5, 15));
      bias = $urandom_range(0, 100);
      for (int i = 0; i < 60; i++)
        cyc($urandom_range(0, 199) == 0, $urandom_range(0, 99) < bias, code);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule